// File: doc/BRIEF.md
# Interrupt Aggregator with Set/Clear Alias Registers

This block gathers up to 32 edge-type interrupt sources into a single active-high request line for a parent interrupt controller. A rising edge on a source input latches that source's bit in a sticky status register. The bit stays set after the input drops, and only software can clear it. A per-source mask register decides which latched bits take part in the summary request. A set mask bit disables its source.

Software reaches the block through a simple word-wide register interface with one write strobe and one read strobe. Status and mask are never written directly. Each one has a write-one-to-set alias and a write-one-to-clear alias, so a single bit can be changed without a read-modify-write sequence. Each one also has a read-only view. Status can also be forced high from software, which allows software-generated interrupts and self-test.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every status bit is 0, every mask bit is 1 (all sources disabled), `irq_o` is 0 and `rd_data_o` is 0.
- R2: A 0-to-1 change of `src_i[k]` between two consecutive clock edges sets status bit k. The bit stays 1 after the input falls. An input that is held high does not set the bit again once it has been cleared.
- R3: A write to byte offset 0x08 clears every status bit whose data bit is 1. Status bits written as 0 keep their value.
- R4: A write to byte offset 0x04 sets every status bit whose data bit is 1. Status bits written as 0 keep their value.
- R5: A write to offset 0x10 sets the mask bits written as 1, and a write to offset 0x14 clears the mask bits written as 1. A read of offset 0x0C returns the mask.
- R6: A read of offset 0x00 returns the full status, masked bits included.
- R7: `irq_o` is high in the cycle after an edge exactly when the pending set (status AND NOT mask) was non-zero at that edge.
- R8: If a rising source edge and a status-clear write of the same bit occur in the same cycle, the bit ends up set.
- R9: Read data appears on `rd_data_o` the cycle after `rd_en_i` is sampled. Reads of the four alias offsets (0x04, 0x08, 0x10, 0x14) and of unmapped offsets return 0, and `rd_data_o` is 0 in any cycle that follows no read.
- R10: A write of all ones to mask-set followed by a write of all ones to status-clear leaves every source disabled, every status bit cleared and `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | W (32) | Interrupt source inputs, one per source |
| addr_i | input | ADDR_W (8) | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | W (32) | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | W (32) | Registered read data |
| irq_o | output | 1 | Registered summary interrupt, active high |

## Verification
The embedded properties assume the following about the inputs:
- Every input is synchronous to `clk` and free of X.
- A write strobe always comes with a stable address and data in the same cycle.

The bench drives every input on the falling clock edge, so each value is settled a half period before the design samples it. Address, data and source patterns are random but always defined. Sources change at most once per cycle, and rising edges are kept sparse so that clears and edges meet in the same cycle often enough to exercise the set-wins rule.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic              rd_en_i,
  output logic [W-1:0]      rd_data_o,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] OFS_STAT   = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_SSET   = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_SCLR   = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_MASK   = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_MSET   = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFS_MCLR   = ADDR_W'(8'h14);

  logic [W-1:0] src_q, status_q, mask_q;
  logic [W-1:0] rise, st_set, st_clr, mk_set, mk_clr, pending, rd_mux;

  assign rise    = src_i & ~src_q;
  assign st_set  = (wr_en_i && addr_i == OFS_SSET) ? wr_data_i : '0;
  assign st_clr  = (wr_en_i && addr_i == OFS_SCLR) ? wr_data_i : '0;
  assign mk_set  = (wr_en_i && addr_i == OFS_MSET) ? wr_data_i : '0;
  assign mk_clr  = (wr_en_i && addr_i == OFS_MCLR) ? wr_data_i : '0;
  assign pending = status_q & ~mask_q;

  always_comb begin
    case (addr_i)
      OFS_STAT: rd_mux = status_q;
      OFS_MASK: rd_mux = mask_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q     <= '0;
      status_q  <= '0;
      mask_q    <= '1;
      irq_o     <= 1'b0;
      rd_data_o <= '0;
    end else begin
      src_q     <= src_i;
      status_q  <= (status_q & ~st_clr) | st_set | rise;
      mask_q    <= (mask_q | mk_set) & ~mk_clr;
      irq_o     <= |pending;
      rd_data_o <= rd_en_i ? rd_mux : '0;
    end
  end

  AST_EDGE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((status_q & $past(rise)) == $past(rise))); // R8

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && addr_i == OFS_SCLR) |=> (($past(status_q) & ~status_q) == '0)); // R2

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == OFS_SCLR) |=>
      ((status_q & $past(wr_data_i) & ~$past(rise)) == '0)); // R3

  AST_FORCE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == OFS_SSET) |=>
      ((status_q & $past(wr_data_i)) == $past(wr_data_i))); // R4

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == OFS_MSET) |=>
      ((mask_q & $past(wr_data_i)) == $past(wr_data_i))); // R5

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == OFS_MCLR) |=> ((mask_q & $past(wr_data_i)) == '0)); // R5

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (((status_q & ~mask_q) == '0)) |=> !irq_o); // R7

  AST_ALIAS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i != OFS_STAT && addr_i != OFS_MASK) |=> (rd_data_o == '0)); // R9

endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] src_i = '0;
  logic [7:0]   addr_i = '0;
  logic         wr_en_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic         rd_en_i = 1'b0;
  logic [W-1:0] rd_data_o;
  logic         irq_o;

  always #2.5 clk = ~clk;

  irq_aggregator #(.W(W), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [W-1:0] m_stat, m_mask, m_prev, exp_rd;
  logic         exp_irq;

  function automatic logic [W-1:0] model_read(logic [7:0] a, logic [W-1:0] st, logic [W-1:0] mk);
    if (a == 8'h00) return st;
    if (a == 8'h0C) return mk;
    return '0;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycle(bit we, bit re, logic [7:0] a, logic [W-1:0] d, logic [W-1:0] s);
    logic [W-1:0] rise;
    wr_en_i = we; rd_en_i = re; addr_i = a; wr_data_i = d; src_i = s;
    rise    = s & ~m_prev;
    exp_rd  = re ? model_read(a, m_stat, m_mask) : '0;
    exp_irq = |(m_stat & ~m_mask);
    if (we && a == 8'h08) m_stat = m_stat & ~d;
    if (we && a == 8'h04) m_stat = m_stat | d;
    m_stat = m_stat | rise;
    if (we && a == 8'h10) m_mask = m_mask | d;
    if (we && a == 8'h14) m_mask = m_mask & ~d;
    m_prev = s;
    @(negedge clk);
    wr_en_i = 1'b0; rd_en_i = 1'b0;
    check("R7 irq", {{(W-1){1'b0}}, irq_o}, {{(W-1){1'b0}}, exp_irq});
    check("R9 rd_data", rd_data_o, exp_rd);
  endtask

  task automatic wr(logic [7:0] a, logic [W-1:0] d); cycle(1, 0, a, d, src_i); endtask
  task automatic rd(logic [7:0] a); cycle(0, 1, a, '0, src_i); endtask
  task automatic src(logic [W-1:0] s); cycle(0, 0, 8'h00, '0, s); endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_stat = '0; m_mask = '1; m_prev = '0;
    repeat (3) @(negedge clk);
    check("R1 rd_data reset", rd_data_o, '0);
    check("R1 irq reset", {31'b0, irq_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h00); check("R1 status reset", rd_data_o, '0);
    rd(8'h0C); check("R1 mask reset", rd_data_o, '1);

    // R2: edge latches, sticky after input falls, masked status still visible (R6)
    src(32'h0000_0011); src(32'h0000_0001);
    rd(8'h00); check("R2/R6 sticky masked", rd_data_o, 32'h0000_0011);
    // R5: unmask, irq follows (R7)
    wr(8'h14, 32'h0000_0010);
    rd(8'h0C); check("R5 mask clr", rd_data_o, 32'hFFFF_FFEF);
    src(32'h0000_0001);
    check("R7 irq high", {31'b0, irq_o}, 1);
    // R3: clear only bit 4, bit 0 kept; held-high input does not refire
    wr(8'h08, 32'h0000_0010);
    src(32'h0000_0001);
    rd(8'h00); check("R3 w1c partial", rd_data_o, 32'h0000_0001);
    wr(8'h08, 32'h0000_0001);
    rd(8'h00); check("R2 no refire on level", rd_data_o, '0);
    // R8: edge and clear on same bit
    src('0);
    cycle(1, 0, 8'h08, 32'h0000_0100, 32'h0000_0100);
    rd(8'h00); check("R8 set wins", rd_data_o, 32'h0000_0100);
    // R4: forced status
    wr(8'h04, 32'h8000_0002);
    rd(8'h00); check("R4 force", rd_data_o, 32'h8000_0102);
    // R9: alias and unmapped reads return 0
    rd(8'h04); check("R9 alias 04", rd_data_o, '0);
    rd(8'h10); check("R9 alias 10", rd_data_o, '0);
    rd(8'h1C); check("R9 unmapped", rd_data_o, '0);
    // R5 mask set
    wr(8'h10, 32'h0000_0010);
    rd(8'h0C); check("R5 mask set", rd_data_o, '1);

    // constrained random phase
    void'($urandom(32'hC0FFEE));
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] offs [8];
      logic [W-1:0] s;
      int k;
      offs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h08};
      k = $urandom_range(0, 7);
      s = src_i ^ ($urandom() & $urandom() & $urandom());
      cycle($urandom_range(0, 1), $urandom_range(0, 1), offs[k],
            ($urandom_range(0, 3) == 0) ? '1 : $urandom(), s);
    end

    // R10: mask all then clear all
    wr(8'h10, '1);
    wr(8'h08, '1);
    src('0);
    rd(8'h00); check("R10 status cleared", rd_data_o, '0);
    rd(8'h0C); check("R10 all masked", rd_data_o, '1);
    check("R10 irq low", {31'b0, irq_o}, '0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule